// File: doc/BRIEF.md
# Zero-Suppressed Pattern Word Formatter

This block sits on a token-passed readout chain. On each gate pulse it latches eight 12-bit slots. Slots 0 to 6 always come from the pattern inputs. Slot 7 comes either from the pattern inputs or from an event counter. The block records which slots hold something worth sending and raises a local request while it holds such data.

When the read-enable token arrives, the block drives a stream of 16-bit words. Each word is placed on the data output for one clock, then strobed for one clock. The stream is an optional all-zero event marker, then a header, then the non-zero data words in rising sub-address order. After the last word, or at once if there is nothing to send, the block raises its pass output to hand the token on.

Zero suppression applies to every data word. The counter word is also dropped when its value has not changed since the previous event, so an event with nothing new to report costs only the pass delay.

Top module: `zsup_fmt`

## Requirements
- R1: After reset, data_o is 0, and wst_o, pass_o, req_o and nz_mask_o are all 0.
- R2: The block captures its inputs on a clock edge where gate_i is high, the block is idle and ren_i is low.
  - Slot k (k < 7) takes pat_i[12k+11:12k].
  - Slot 7 takes cnt_i when cnt_en_i is high, and pat_i[95:84] otherwise.
  - From the next cycle, nz_mask_o bit k (k = 0..7) is 1 when pattern slot k is non-zero. Bit 7 is forced to 0 while the counter owns slot 7.
  - nz_mask_o bit 8 is 1 when the counter word is to be sent.
  - req_o is 1 exactly when nz_mask_o is non-zero.
- R3: The counter word is sent only when all of these hold:
  - cnt_en_i was high at capture.
  - The captured value is non-zero.
  - The value differs from the one captured at the previous capture with the counter enabled. The value before the first such capture is 0.
- R4: On the first edge where ren_i is high while the block is idle, the stream is built in this order:
  - the marker word 0x0000, only if mark_en_i is high;
  - the header, only if any data word is pending;
  - the pending data words, in ascending sub-address order.
- R5: The header has bit 15 = 1, bits 14:12 = number of data words modulo 8, bits 11:8 = 0 and bits 7:0 = vsn_i.
- R6: A data word has bit 15 = 0, bits 14:12 = sub-address and bits 11:0 = the captured slot value. A slot whose value is zero is never sent.
- R7: The first word is driven on data_o in the cycle after ren_i is accepted, with wst_o low.
  - In the following cycle wst_o is high and data_o is unchanged.
  - The next word follows directly.
  - data_o is 0 whenever no word is being driven.
- R8: pass_o goes high in the cycle after the last strobe, or in the cycle after ren_i is accepted when no word is to be sent. It stays high while ren_i stays high.
- R9: When ren_i is low at an edge while the block is busy, the block returns to idle in the next cycle. The captured event is discarded, so nz_mask_o and req_o become 0 and the remaining words are dropped.
- R10: gate_i has no effect from the edge that accepts ren_i until the block has returned to idle, or when it is high at the same edge as an accepted ren_i.
- R11: An event with eight data words writes 0 in the header count field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Capture strobe for a new event |
| ren_i | input | 1 | Read-enable token from the previous stage |
| pat_i | input | 96 | Eight 12-bit pattern slots, slot k at bits 12k+11:12k |
| cnt_i | input | 12 | Event counter value |
| vsn_i | input | 8 | Station number placed in the header |
| mark_en_i | input | 1 | Emit the leading zero marker word |
| cnt_en_i | input | 1 | Slot 7 carries the counter instead of pattern bits |
| data_o | output | 16 | Output word |
| wst_o | output | 1 | Write strobe for the word on data_o |
| pass_o | output | 1 | Token passed to the next stage |
| req_o | output | 1 | Local request: pending data held |
| nz_mask_o | output | 9 | Pending-word mask: bits 7:0 pattern slots, bit 8 counter |

## Verification
A corrupted capture register shows on nz_mask_o and req_o in the cycle right after the gate. The same fault reappears as a wrong header count or a wrong data word within two cycles of the token being accepted. A pending-word vector that clears the wrong bit shows up within two cycles as:
- a repeated or missing word on data_o;
- a strobe in the wrong cycle;
- pass_o rising early or late.

A reference model stepped every clock catches any of these in the cycle they first appear. Directed event streams pin down the exact word values, including the count wrap, the counter-change rule and the abort path.

// File: rtl/zsup_pkg.sv
package zsup_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_PUT,
    S_STRB,
    S_DONE
  } seq_st_e;
endpackage

// File: rtl/zsup_capture.sv
module zsup_capture #(
  parameter int NW = 8,
  parameter int DW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clr_i,
  input  logic [NW*DW-1:0] pat_i,
  input  logic [DW-1:0]    cnt_i,
  input  logic             cnt_en_i,
  output logic [NW*DW-1:0] words_o,
  output logic [NW-1:0]    send_o,
  output logic [NW:0]      mask_o
);
  logic [DW-1:0] slot_d [NW];
  logic [DW-1:0] word_q [NW];
  logic [NW-1:0] pnz;
  logic [NW:0]   mask_q;
  logic [DW-1:0] last_q;
  logic          cnt_pend;

  for (genvar k = 0; k < NW; k++) begin : g_slot
    if (k == NW - 1) begin : g_shared
      assign slot_d[k] = cnt_en_i ? cnt_i : pat_i[k*DW +: DW];
      assign pnz[k]    = !cnt_en_i && (pat_i[k*DW +: DW] != '0);
    end else begin : g_pat
      assign slot_d[k] = pat_i[k*DW +: DW];
      assign pnz[k]    = pat_i[k*DW +: DW] != '0;
    end
    assign words_o[k*DW +: DW] = word_q[k];
  end

  // counter only reported when it moved since the last enabled capture
  assign cnt_pend = cnt_en_i && (cnt_i != '0) && (cnt_i != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      last_q <= '0;
      for (int k = 0; k < NW; k++) word_q[k] <= '0;
    end else if (take_i) begin
      mask_q <= {cnt_pend, pnz};
      if (cnt_en_i) last_q <= cnt_i;
      for (int k = 0; k < NW; k++) word_q[k] <= slot_d[k];
    end else if (clr_i) begin
      mask_q <= '0;
      for (int k = 0; k < NW; k++) word_q[k] <= '0;
    end
  end

  assign mask_o = mask_q;
  assign send_o = mask_q[NW-1:0] | {mask_q[NW], {(NW-1){1'b0}}};
endmodule

// File: rtl/zsup_seq.sv
module zsup_seq #(
  parameter int NW = 8,
  parameter int DW = 12,
  parameter int VW = 8,
  localparam int SAW = $clog2(NW),
  localparam int OW  = 1 + SAW + DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_i,
  input  logic             mark_en_i,
  input  logic [VW-1:0]    vsn_i,
  input  logic [NW*DW-1:0] words_i,
  input  logic [NW-1:0]    send_i,
  output logic [OW-1:0]    data_o,
  output logic             wst_o,
  output logic             pass_o,
  output logic             busy_o,
  output logic             clr_o
);
  import zsup_pkg::*;

  localparam int PW = NW + 2;
  localparam int SW = $clog2(NW + 2);
  localparam int PADW = OW - 1 - SAW - VW;
  localparam logic [SW-1:0] SEL_MK = SW'(NW + 1);
  localparam logic [SW-1:0] SEL_HD = SW'(NW);

  seq_st_e       st_q;
  logic [PW-1:0] pend_q, src, start;
  logic [SW-1:0] sel;
  logic [SAW-1:0] sa, wc;
  logic [OW-1:0] word;
  logic [OW-1:0] data_q;

  always_comb begin
    wc = '0;
    for (int k = 0; k < NW; k++) wc += SAW'(send_i[k]);
  end

  assign start = {mark_en_i, |send_i, send_i};
  assign src   = (st_q == S_IDLE) ? start : pend_q;

  // priority: marker, header, then lowest sub-address
  always_comb begin
    sel = '0;
    for (int k = NW - 1; k >= 0; k--) if (src[k]) sel = SW'(k);
    if (src[NW])     sel = SEL_HD;
    if (src[NW + 1]) sel = SEL_MK;
  end

  assign sa = sel[SAW-1:0];

  always_comb begin
    if (sel == SEL_MK)      word = '0;
    else if (sel == SEL_HD) word = {1'b1, wc, {PADW{1'b0}}, vsn_i};
    else                    word = {1'b0, sa, words_i[sa*DW +: DW]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (ren_i) begin
          if (|src) begin
            data_q <= word;
            pend_q <= src & ~(PW'(1) << sel);
            st_q   <= S_PUT;
          end else begin
            st_q <= S_DONE;
          end
        end
        S_PUT: begin
          if (!ren_i) begin
            data_q <= '0;
            pend_q <= '0;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_STRB;
          end
        end
        S_STRB: begin
          if (!ren_i) begin
            data_q <= '0;
            pend_q <= '0;
            st_q   <= S_IDLE;
          end else if (|src) begin
            data_q <= word;
            pend_q <= src & ~(PW'(1) << sel);
            st_q   <= S_PUT;
          end else begin
            data_q <= '0;
            st_q   <= S_DONE;
          end
        end
        S_DONE: if (!ren_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign data_o = data_q;
  assign wst_o  = st_q == S_STRB;
  assign pass_o = st_q == S_DONE;
  assign busy_o = st_q != S_IDLE;
  assign clr_o  = busy_o && !ren_i;
endmodule

// File: rtl/zsup_fmt.sv
module zsup_fmt #(
  parameter int NW = 8,
  parameter int DW = 12,
  parameter int VW = 8,
  localparam int SAW = $clog2(NW),
  localparam int OW  = 1 + SAW + DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             ren_i,
  input  logic [NW*DW-1:0] pat_i,
  input  logic [DW-1:0]    cnt_i,
  input  logic [VW-1:0]    vsn_i,
  input  logic             mark_en_i,
  input  logic             cnt_en_i,
  output logic [OW-1:0]    data_o,
  output logic             wst_o,
  output logic             pass_o,
  output logic             req_o,
  output logic [NW:0]      nz_mask_o
);
  logic             busy, clr, take;
  logic [NW*DW-1:0] words;
  logic [NW-1:0]    send;

  assign take = gate_i && !busy && !ren_i;

  zsup_capture #(.NW(NW), .DW(DW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .clr_i   (clr),
    .pat_i   (pat_i),
    .cnt_i   (cnt_i),
    .cnt_en_i(cnt_en_i),
    .words_o (words),
    .send_o  (send),
    .mask_o  (nz_mask_o)
  );

  zsup_seq #(.NW(NW), .DW(DW), .VW(VW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ren_i    (ren_i),
    .mark_en_i(mark_en_i),
    .vsn_i    (vsn_i),
    .words_i  (words),
    .send_i   (send),
    .data_o   (data_o),
    .wst_o    (wst_o),
    .pass_o   (pass_o),
    .busy_o   (busy),
    .clr_o    (clr)
  );

  assign req_o = |send;
endmodule

// File: rtl/zsup_fmt_chk.sv
module zsup_fmt_chk #(
  parameter int NW = 8,
  parameter int DW = 12,
  parameter int VW = 8,
  localparam int SAW = $clog2(NW),
  localparam int OW  = 1 + SAW + DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ren_i,
  input logic [VW-1:0] vsn_i,
  input logic [OW-1:0] data_o,
  input logic          wst_o,
  input logic          pass_o,
  input logic [NW:0]   nz_mask_o
);
  logic [SAW-1:0] mask_cnt;
  assign mask_cnt = SAW'($countones(nz_mask_o));

  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wst_o |=> !wst_o);

  p_strobe_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wst_o |-> $stable(data_o));

  p_pass_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (!wst_o && data_o == '0));

  p_ren_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_i |=> (!wst_o && !pass_o));

  p_hdr_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wst_o && data_o[OW-1]) |-> (data_o[OW-2 -: SAW] == mask_cnt));

  p_hdr_vsn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wst_o && data_o[OW-1]) |-> (data_o[VW-1:0] == vsn_i));

  p_no_zero_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wst_o && !data_o[OW-1] && data_o[OW-2 -: SAW] != '0) |-> (data_o[DW-1:0] != '0));
endmodule

bind zsup_fmt zsup_fmt_chk #(.NW(NW), .DW(DW), .VW(VW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ren_i    (ren_i),
  .vsn_i    (vsn_i),
  .data_o   (data_o),
  .wst_o    (wst_o),
  .pass_o   (pass_o),
  .nz_mask_o(nz_mask_o)
);

// File: tb/sim_zsup_fmt.sv
`timescale 1ns/1ps
module sim_zsup_fmt;
  logic        clk, rst_n, gate, ren, mark_en, cnt_en;
  logic [95:0] pat;
  logic [11:0] cnt;
  logic [7:0]  vsn;
  logic [15:0] data_o;
  logic        wst_o, pass_o, req_o;
  logic [8:0]  nz_mask_o;

  int n_chk = 0, n_err = 0;
  bit done = 0, cmp_on = 0;

  zsup_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .gate_i(gate), .ren_i(ren), .pat_i(pat),
    .cnt_i(cnt), .vsn_i(vsn), .mark_en_i(mark_en), .cnt_en_i(cnt_en),
    .data_o(data_o), .wst_o(wst_o), .pass_o(pass_o), .req_o(req_o),
    .nz_mask_o(nz_mask_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: queue of words, two cycles each
  bit          m_busy, m_active, m_ph, m_pass;
  logic [15:0] m_cur;
  logic [15:0] m_q[$];
  logic [11:0] m_w[8];
  logic [8:0]  m_mask;
  logic [11:0] m_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_active = 0; m_ph = 0; m_pass = 0; m_cur = 0;
      m_mask = 0; m_last = 0; m_q.delete();
      for (int k = 0; k < 8; k++) m_w[k] = 0;
    end else if (!m_busy) begin
      if (ren) begin
        logic [7:0] sb;
        int n;
        sb = m_mask[7:0] | {m_mask[8], 7'b0};
        n = 0;
        m_q.delete();
        if (mark_en) m_q.push_back(16'h0000);
        for (int k = 0; k < 8; k++) if (sb[k]) n++;
        if (n > 0) m_q.push_back({1'b1, 3'(n), 4'h0, vsn});
        for (int k = 0; k < 8; k++) if (sb[k]) m_q.push_back({1'b0, 3'(k), m_w[k]});
        m_busy = 1;
        if (m_q.size() == 0) m_pass = 1;
        else begin m_cur = m_q.pop_front(); m_ph = 0; m_active = 1; end
      end else if (gate) begin
        for (int k = 0; k < 8; k++) begin
          m_w[k] = pat[k*12 +: 12];
          m_mask[k] = (m_w[k] != 0);
        end
        m_mask[8] = 0;
        if (cnt_en) begin
          m_w[7] = cnt;
          m_mask[7] = 0;
          m_mask[8] = (cnt != 0) && (cnt != m_last);
          m_last = cnt;
        end
      end
    end else begin
      if (!ren) begin
        m_busy = 0; m_active = 0; m_pass = 0; m_mask = 0;
        for (int k = 0; k < 8; k++) m_w[k] = 0;
      end else if (m_active) begin
        if (!m_ph) m_ph = 1;
        else if (m_q.size() > 0) begin m_cur = m_q.pop_front(); m_ph = 0; end
        else begin m_active = 0; m_pass = 1; end
      end
    end
  end

  always @(negedge clk) if (cmp_on && rst_n) begin
    logic [15:0] e_data;
    e_data = m_active ? m_cur : 16'h0;
    chk(data_o === e_data, "R7 data_o cycle", 32'(data_o), 32'(e_data));
    chk(wst_o === (m_active && m_ph), "R7 wst_o cycle", 32'(wst_o), 32'(m_active && m_ph));
    chk(pass_o === m_pass, "R8 pass_o cycle", 32'(pass_o), 32'(m_pass));
    chk({req_o, nz_mask_o} === {m_mask != 0, m_mask}, "R2 req/mask cycle",
        32'({req_o, nz_mask_o}), 32'({m_mask != 0, m_mask}));
  end

  logic [15:0] log_q[$];
  always @(negedge clk) if (rst_n && wst_o) log_q.push_back(data_o);

  task automatic cmp_stream(input string tag, input logic [15:0] exp[$]);
    chk(log_q.size() == exp.size(), {tag, " word count"}, 32'(log_q.size()), 32'(exp.size()));
    for (int i = 0; i < exp.size() && i < log_q.size(); i++)
      chk(log_q[i] === exp[i], {tag, " word"}, 32'(log_q[i]), 32'(exp[i]));
  endtask

  task automatic do_gate(input logic [95:0] p, input logic [11:0] c, input bit ce, input bit me);
    @(negedge clk);
    pat = p; cnt = c; cnt_en = ce; mark_en = me; gate = 1;
    @(negedge clk);
    gate = 0;
  endtask

  task automatic read_out();
    log_q.delete();
    ren = 1;
    for (int i = 0; i < 60 && !pass_o; i++) @(negedge clk);
    ren = 0;
    @(negedge clk);
  endtask

  function automatic logic [95:0] ramp(input logic [11:0] base);
    logic [95:0] p;
    for (int k = 0; k < 8; k++) p[k*12 +: 12] = base + 12'(k);
    return p;
  endfunction

  initial begin
    logic [15:0] e[$];
    rst_n = 0; gate = 0; ren = 0; mark_en = 0; cnt_en = 0; pat = '0; cnt = '0; vsn = 8'h5A;
    repeat (3) @(negedge clk);
    chk(data_o == 0 && !wst_o && !pass_o && !req_o && nz_mask_o == 0, "R1 reset",
        32'({data_o, wst_o, pass_o, req_o, nz_mask_o}), 32'h0);
    rst_n = 1;
    cmp_on = 1;

    // A: marker on, slots 0 and 3
    do_gate({60'h0, 12'hABC, 24'h0, 12'h123}, 12'h0, 0, 1);
    chk(nz_mask_o == 9'h009 && req_o, "R2 mask after gate", 32'(nz_mask_o), 32'h009);
    read_out();
    e = '{16'h0000, 16'hA05A, 16'h0123, 16'h3ABC};
    cmp_stream("R4 R6 marker+header+data", e);

    // B: nothing pending, no marker: pass at once
    do_gate('0, 12'h0, 0, 0);
    log_q.delete();
    ren = 1;
    @(negedge clk);
    chk(pass_o === 1'b1, "R8 immediate pass", 32'(pass_o), 32'h1);
    ren = 0;
    @(negedge clk);
    e = {};
    cmp_stream("R5 no header when empty", e);

    // C: counter owns slot 7, eight words -> count 0
    do_gate(ramp(12'h001), 12'h005, 1, 0);
    chk(nz_mask_o == 9'h17F, "R2 R3 mask counter", 32'(nz_mask_o), 32'h17F);
    read_out();
    e = '{16'h805A, 16'h0001, 16'h1002, 16'h2003, 16'h3004, 16'h4005, 16'h5006, 16'h6007, 16'h7005};
    cmp_stream("R11 R3 counter slot", e);

    // D: counter unchanged -> not sent
    do_gate({72'h0, 12'h010, 12'h0, 12'h0}, 12'h005, 1, 0);
    chk(nz_mask_o == 9'h004, "R3 unchanged counter", 32'(nz_mask_o), 32'h004);
    read_out();
    e = '{16'h905A, 16'h2010};
    cmp_stream("R3 R5 single word", e);

    // E: counter off, all eight pattern slots, new station number
    vsn = 8'hC3;
    do_gate(ramp(12'h100), 12'h0, 0, 0);
    chk(nz_mask_o == 9'h0FF, "R2 slot7 pattern", 32'(nz_mask_o), 32'h0FF);
    read_out();
    e = '{16'h80C3, 16'h0100, 16'h1101, 16'h2102, 16'h3103, 16'h4104, 16'h5105, 16'h6106, 16'h7107};
    cmp_stream("R11 R6 eight pattern words", e);

    // F: counter changed to zero -> suppressed
    do_gate({84'h0, 12'h00F}, 12'h000, 1, 0);
    read_out();
    e = '{16'h90C3, 16'h000F};
    cmp_stream("R3 zero counter", e);

    // G: only the counter changed
    do_gate('0, 12'h7FF, 1, 0);
    chk(nz_mask_o == 9'h100 && req_o, "R3 counter only", 32'(nz_mask_o), 32'h100);
    read_out();
    e = '{16'h90C3, 16'h77FF};
    cmp_stream("R3 counter word", e);

    // H: abort mid stream
    do_gate(ramp(12'h200), 12'h0, 0, 1);
    log_q.delete();
    ren = 1;
    repeat (3) @(negedge clk);
    ren = 0;
    @(negedge clk);
    chk(!req_o && nz_mask_o == 0, "R9 abort clears event", 32'({req_o, nz_mask_o}), 32'h0);
    chk(log_q.size() == 1, "R9 words before abort", 32'(log_q.size()), 32'h1);
    log_q.delete();
    repeat (2) @(negedge clk);
    chk(log_q.size() == 0 && !wst_o, "R9 no words after abort", 32'(log_q.size()), 32'h0);

    // I: gate during readout and together with ren ignored
    do_gate({84'h0, 12'h0AA}, 12'h0, 0, 0);
    log_q.delete();
    ren = 1;
    pat = ramp(12'h300); gate = 1;
    @(negedge clk);
    @(negedge clk);
    gate = 0;
    for (int i = 0; i < 20 && !pass_o; i++) @(negedge clk);
    ren = 0;
    @(negedge clk);
    e = '{16'h90C3, 16'h00AA};
    cmp_stream("R10 stream unaffected", e);
    chk(nz_mask_o == 0 && !req_o, "R10 no late capture", 32'(nz_mask_o), 32'h0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule